// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This block turns the operand field of a one-operand instruction into a memory address. The field has a mode and a register number. It reads the operand at that address, then holds both the address and the value for the execute stage. The execute stage computes a result and either asks for it to be written back to the same address or abandons the operation.

General registers are not kept in flip-flops. They live in memory at the workspace pointer plus twice the register number, so register-direct operands are memory accesses too. The memory port is a single request/acknowledge channel, and the memory may stretch any access by holding the acknowledge low.

The address is resolved once per instruction, and this includes the auto-increment side effect and any extension-word fetch. The write-back reuses the stored address, so no side effect happens a second time.

Top module: `operand_addr_unit`

## Requirements
- R1: Mode 2'b00 (register direct) gives the effective address workspace_ptr + 2*reg, and the operand is the word stored there.
- R2: Mode 2'b01 (register indirect) reads the register word and uses its contents as the effective address.
- R3: Mode 2'b11 (auto-increment) uses the old register contents as the effective address. It writes contents+2 back to the register word exactly once, and the write-back does not repeat this update.
- R4: Mode 2'b10 with register 0 (symbolic) fetches one extension word at `pc_in` and uses it as the effective address. `pc_adv` pulses exactly once in that instruction.
- R5: Mode 2'b10 with a nonzero register (indexed) fetches the extension word at `pc_in` as an offset. The effective address is the register contents plus that offset, modulo 2^16, and `pc_adv` pulses exactly once.
- R6: While `done` is high and neither `wr_req` nor `abort` is raised, `done`, `ea` and `operand` stay high and unchanged.
- R7: `wr_req` raised during `done` writes `wr_data`, captured in that cycle, to the held effective address.
- R8: `abort` during `done` returns the block to idle with no memory write. If `abort` and `wr_req` are raised together, `abort` wins.
- R9: After reset, `busy`, `done` and `mem_req` are low.
- R10: A request that is not acknowledged keeps `mem_req`, `mem_addr` and `mem_we` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving an operand (sampled when idle) |
| mode | input | 2 | Addressing mode field |
| reg_num | input | 4 | Register number field |
| wp | input | 16 | Workspace pointer (byte address) |
| pc_in | input | 16 | Address of the next instruction-stream word |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Effective address and operand are valid |
| ea | output | 16 | Resolved effective address |
| operand | output | 16 | Operand word read from `ea` |
| pc_adv | output | 1 | Extension word consumed; PC should advance by 2 |
| wr_req | input | 1 | Write the result back to `ea` |
| wr_data | input | 16 | Result to write |
| abort | input | 1 | Drop the operation without writing |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |

## Verification
The two actions that can fall on the same cycle are the write-back request and the abort, because both are accepted from the held state. The sweep ends every mode/register/stall combination in three ways: a write, an abort, and both raised on one cycle. In the third case the target word must be unchanged and the register word must show at most its single auto-increment. The memory acknowledge is also stalled on alternate cycles, which interleaves held requests with every state.

// File: rtl/operand_addr_unit.sv
module operand_addr_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic [3:0]  reg_num,
  input  logic [15:0] wp,
  input  logic [15:0] pc_in,
  output logic        busy,
  output logic        done,
  output logic [15:0] ea,
  output logic [15:0] operand,
  output logic        pc_adv,
  input  logic        wr_req,
  input  logic [15:0] wr_data,
  input  logic        abort,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ack
);

  typedef enum logic [2:0] {
    S_IDLE, S_EXT, S_REG, S_INC, S_OPR, S_HOLD, S_WB
  } state_t;

  state_t      st;
  logic [1:0]  md;
  logic [3:0]  rn;
  logic [15:0] ea_r, opnd_r, ofs, wdat;
  logic [15:0] reg_addr;

  assign reg_addr  = wp + {11'd0, rn, 1'b0};
  assign busy      = st != S_IDLE;
  assign done      = st == S_HOLD;
  assign ea        = ea_r;
  assign operand   = opnd_r;
  assign pc_adv    = st == S_EXT && mem_ack;
  assign mem_req   = st == S_EXT || st == S_REG || st == S_INC || st == S_OPR || st == S_WB;
  assign mem_we    = st == S_INC || st == S_WB;
  assign mem_wdata = st == S_WB ? wdat : ea_r + 16'd2;

  always_comb begin
    case (st)
      S_EXT:        mem_addr = pc_in;
      S_REG, S_INC: mem_addr = reg_addr;
      default:      mem_addr = ea_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      md     <= 2'b00;
      rn     <= 4'd0;
      ea_r   <= 16'd0;
      opnd_r <= 16'd0;
      ofs    <= 16'd0;
      wdat   <= 16'd0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          md <= mode;
          rn <= reg_num;
          case (mode)
            2'b00: begin
              ea_r <= wp + {11'd0, reg_num, 1'b0};
              st   <= S_OPR;
            end
            2'b10:   st <= S_EXT;
            default: st <= S_REG;
          endcase
        end
        S_EXT: if (mem_ack) begin
          if (rn == 4'd0) begin
            ea_r <= mem_rdata;
            st   <= S_OPR;
          end else begin
            ofs <= mem_rdata;
            st  <= S_REG;
          end
        end
        S_REG: if (mem_ack) begin
          if (md == 2'b10) begin
            ea_r <= mem_rdata + ofs;
            st   <= S_OPR;
          end else begin
            ea_r <= mem_rdata;
            st   <= (md == 2'b11) ? S_INC : S_OPR;
          end
        end
        S_INC: if (mem_ack) st <= S_OPR;
        S_OPR: if (mem_ack) begin
          opnd_r <= mem_rdata;
          st     <= S_HOLD;
        end
        S_HOLD: begin
          if (abort) st <= S_IDLE;
          else if (wr_req) begin
            wdat <= wr_data;
            st   <= S_WB;
          end
        end
        S_WB: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module oau_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        busy,
  input logic [15:0] ea,
  input logic [15:0] operand,
  input logic [15:0] pc_in,
  input logic        pc_adv,
  input logic        wr_req,
  input logic [15:0] wr_data,
  input logic        abort,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_ack
);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wr_req && !abort |=> done && $stable(ea) && $stable(operand));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_ext_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |-> mem_req && !mem_we && mem_addr == pc_in);

  assert_abort_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && abort |=> !(mem_req && mem_we) && !done);

  assert_wb_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && wr_req && !abort |=> mem_req && mem_we && mem_addr == $past(ea) && mem_wdata == $past(wr_data));

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy && !done && !mem_req);

endmodule

bind operand_addr_unit oau_chk u_chk (.*);

// File: tb/sim_operand_addr_unit.sv
module sim_operand_addr_unit;
  logic clk = 0;
  always #4 clk = ~clk;

  logic        rst_n = 0, start = 0, wr_req = 0, abort = 0;
  logic [1:0]  mode = 0;
  logic [3:0]  reg_num = 0;
  logic [15:0] wp = 16'h0040, pc_in = 16'h0200, wr_data = 0;
  logic        busy, done, pc_adv, mem_req, mem_we, mem_ack;
  logic [15:0] ea, operand, mem_addr, mem_wdata, mem_rdata;

  logic [15:0] mem [512];
  logic        slow = 0, tgl = 0, init = 0;
  logic [15:0] ext_val = 0;
  int          pc_cnt = 0;
  int          checks = 0, errors = 0;

  operand_addr_unit u0 (.*);

  assign mem_ack   = mem_req && (!slow || tgl);
  assign mem_rdata = mem[mem_addr[9:1]];

  function automatic logic [15:0] pat(int i);
    return 16'(i * 16'h0123) ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] regv(int r);
    return 16'h0100 + 16'(r * 8);
  endfunction

  always @(posedge clk) begin
    tgl <= ~tgl;
    if (pc_adv) pc_cnt <= pc_cnt + 1;
    if (init) begin
      for (int i = 0; i < 512; i++) mem[i] <= pat(i);
      for (int r = 0; r < 16; r++) mem[32 + r] <= regv(r);
      mem[256] <= ext_val;
      pc_cnt <= 0;
    end else if (mem_req && mem_we && mem_ack)
      mem[mem_addr[9:1]] <= mem_wdata;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(int m, int r, int endk);
    logic [15:0] e_ea, e_op, e_reg, e_tgt;
    string tag;
    int n;
    ext_val = (m == 2 && r == 0) ? 16'h01F0 : 16'h0004;
    @(negedge clk); init = 1;
    @(negedge clk); init = 0;
    case (m)
      0: begin e_ea = 16'h0040 + 16'(2 * r); e_op = regv(r); tag = "R1"; end
      1: begin e_ea = regv(r); e_op = pat(e_ea[9:1]); tag = "R2"; end
      3: begin e_ea = regv(r); e_op = pat(e_ea[9:1]); tag = "R3"; end
      default: begin
        if (r == 0) begin e_ea = 16'h01F0; tag = "R4"; end
        else begin e_ea = regv(r) + 16'h0004; tag = "R5"; end
        e_op = pat(e_ea[9:1]);
      end
    endcase
    mode = 2'(m); reg_num = 4'(r); start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    chk({tag, " done"}, 16'(done), 16'd1);
    chk({tag, " ea"}, ea, e_ea);
    chk({tag, " operand"}, operand, e_op);
    chk({tag, " pc_adv count"}, 16'(pc_cnt), (m == 2) ? 16'd1 : 16'd0);
    repeat (3) @(negedge clk);
    chk("R6 held ea", ea, e_ea);
    chk("R6 held operand", operand, e_op);
    chk("R6 held done", 16'(done), 16'd1);
    wr_data = ~e_op;
    wr_req = (endk != 1);
    abort  = (endk != 0);
    @(negedge clk); wr_req = 0; abort = 0; wr_data = 16'h0;
    n = 0;
    while (busy && n < 50) begin @(negedge clk); n++; end
    chk("R8 idle after end", 16'(busy), 16'd0);
    e_reg = (m == 3) ? regv(r) + 16'd2 : regv(r);
    e_tgt = (m == 0) ? regv(r) : pat(e_ea[9:1]);
    if (endk == 0) begin
      e_tgt = ~e_op;
      if (m == 0) e_reg = ~e_op;
      chk("R7 written word", mem[e_ea[9:1]], e_tgt);
    end else
      chk("R8 target untouched", mem[e_ea[9:1]], e_tgt);
    chk((m == 3) ? "R3 register once" : "R7 register word", mem[32 + r], e_reg);
    chk("R4 R5 pc_adv total", 16'(pc_cnt), (m == 2) ? 16'd1 : 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", 16'(busy), 16'd0);
    chk("R9 mem_req in reset", 16'(mem_req), 16'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 done after reset", 16'(done), 16'd0);
    for (int s = 0; s < 2; s++) begin
      slow = s[0];
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 16; r++)
          for (int k = 0; k < 3; k++)
            run(m, r, k);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule